// File: doc/BRIEF.md
# Software Interrupt Generator and Source Tracker

This block produces software-generated interrupts for a distributor that serves up to eight CPUs, each with sixteen such interrupts. A CPU requests one by writing a generate word. The access carries the CPU's number. The block decodes the SGI number, a filter mode and a target list from that word. For every selected target, it records the requesting CPU as a source of that SGI.

The state is a small mask for each target and each SGI, holding one bit per requesting CPU. An SGI is pending for a target exactly when its source mask is nonzero. Two banked windows expose the masks, one byte per SGI. A CPU reads its own masks through either window. It can OR bits in through the set window and remove them through the clear window. The pending vector and all source masks are driven straight out to the downstream arbitration logic.

Top module: `sgi_tracker`

## Requirements
- R1: After reset every source mask is zero and no SGI is pending.
- R2: A write to offset 0x00 is a generate request, and the following fields apply:
  - the SGI number is in bits [3:0];
  - the target list is in bits [23:16], where bit 16+n selects CPU n;
  - the filter mode is in bits [25:24].
  In mode 0, each listed target gets the requester's bit ORed into its mask for that SGI. The requester may list itself.
- R3: In mode 1 the targets are all present CPUs except the requester, and the target list is ignored.
- R4: In mode 2 the only target is the requester itself.
- R5: A mode 3 generate write changes no state.
- R6: A CPU is present when its number is below `cpus_present`. List bits for CPUs that are not present have no effect.
- R7: A read of offset 0x00 returns zero.
- R8: For each target t and SGI s, `sgi_pending[t*16+s]` is 1 exactly when the mask at `sgi_source[(t*16+s)*8 +: 8]` is nonzero.
- R9: Reads in the windows return the accessing CPU's own source masks, and the result appears on `rd_data` with `rd_valid` one cycle after the access. The clear window is at 0x10–0x1F and the set window is at 0x20–0x2F.
  - A word access ignores address bits [1:0], and byte lane i holds SGI {addr[3:2], i}.
  - A byte access selects SGI addr[3:0], returns it in bits [7:0], and returns zero above that.
- R10: A set-window write ORs each written byte into the accessing CPU's mask for the corresponding SGI.
- R11: A clear-window write removes the written bits from the accessing CPU's masks. The SGI stops pending once its mask reaches zero.
- R12: A byte write (`acc_byte`=1) takes its data from bits [7:0] and changes only the addressed SGI. The other SGIs of the word keep their masks.
- R13: Without a write access, no source mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpus_present | input | 4 | Number of present CPUs (1 to 8), static |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | 1 = 8-bit access, 0 = 32-bit access |
| acc_cpu | input | 3 | Number of the accessing CPU |
| acc_addr | input | 6 | Byte offset within the block |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| sgi_pending | output | 128 | Pending flag per target and SGI |
| sgi_source | output | 1024 | Source mask per target and SGI |

## Verification
The assertions check several properties on every cycle:
- source masks hold steady between writes;
- a reserved-mode request leaves them unchanged;
- a generate request never alters the masks of absent CPUs;
- a self-only request always leaves the requester's bit set;
- the generate offset reads as zero;
- byte reads are zero above bit 7.

Other properties only the bench scenarios can show, because they depend on the exact target set and byte-lane mapping:
- which targets a list or all-but-self request reaches;
- that the read windows are banked to the accessing CPU;
- that a byte write spares its neighbours in the word;
- that clearing the last source bit drops the pending flag while a partial clear keeps it.

// File: rtl/sgi_tracker.sv
module sgi_tracker #(
  parameter int NCPU = 8,
  parameter int NSGI = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(NCPU+1)-1:0]    cpus_present,
  input  logic                         acc_valid,
  input  logic                         acc_write,
  input  logic                         acc_byte,
  input  logic [$clog2(NCPU)-1:0]      acc_cpu,
  input  logic [5:0]                   acc_addr,
  input  logic [31:0]                  acc_wdata,
  output logic                         rd_valid,
  output logic [31:0]                  rd_data,
  output logic [NCPU*NSGI-1:0]         sgi_pending,
  output logic [NCPU*NSGI*NCPU-1:0]    sgi_source
);
  localparam int SW = $clog2(NSGI);

  logic [NCPU-1:0] src_q [NCPU][NSGI];

  wire is_gen = acc_addr[5:2] == 4'h0;
  wire is_clr = acc_addr[5:4] == 2'b01;
  wire is_set = acc_addr[5:4] == 2'b10;
  wire is_win = is_clr | is_set;
  wire wr     = acc_valid & acc_write;

  wire [1:0]      gen_mode = acc_wdata[25:24];
  wire [SW-1:0]   gen_sgi  = acc_wdata[SW-1:0];
  wire [NCPU-1:0] present  = NCPU'((32'd1 << cpus_present) - 32'd1);
  wire [NCPU-1:0] self_bit = NCPU'(1) << acc_cpu;

  logic [NCPU-1:0] targets;
  always_comb begin
    case (gen_mode)
      2'd0:    targets = acc_wdata[16 +: NCPU] & present;
      2'd1:    targets = present & ~self_bit;
      2'd2:    targets = self_bit;
      default: targets = '0;
    endcase
  end

  logic [SW-1:0] lane_sgi [4];
  logic [3:0]    lane_en;
  logic [7:0]    lane_wd  [4];
  always_comb begin
    for (int b = 0; b < 4; b++) begin
      lane_sgi[b] = acc_byte ? acc_addr[SW-1:0] : {acc_addr[SW-1:2], 2'(b)};
      lane_en[b]  = acc_byte ? (b == 0) : 1'b1;
      lane_wd[b]  = acc_byte ? acc_wdata[7:0] : acc_wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NCPU; t++)
        for (int s = 0; s < NSGI; s++)
          src_q[t][s] <= '0;
    end else if (wr) begin
      if (is_gen) begin
        for (int t = 0; t < NCPU; t++)
          if (targets[t])
            src_q[t][gen_sgi] <= src_q[t][gen_sgi] | self_bit;
      end
      if (is_win) begin
        for (int b = 0; b < 4; b++)
          if (lane_en[b]) begin
            if (is_set)
              src_q[acc_cpu][lane_sgi[b]] <= src_q[acc_cpu][lane_sgi[b]] | lane_wd[b][NCPU-1:0];
            else
              src_q[acc_cpu][lane_sgi[b]] <= src_q[acc_cpu][lane_sgi[b]] & ~lane_wd[b][NCPU-1:0];
          end
      end
    end
  end

  logic [31:0] rd_next;
  logic [7:0]  rbyte;
  always_comb begin
    rd_next = '0;
    for (int b = 0; b < 4; b++) begin
      rbyte = '0;
      rbyte[NCPU-1:0] = src_q[acc_cpu][lane_sgi[b]];
      if (is_win && lane_en[b]) rd_next[8*b +: 8] = rbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid & ~acc_write;
      rd_data  <= (acc_valid & ~acc_write) ? rd_next : '0;
    end
  end

  for (genvar t = 0; t < NCPU; t++) begin : g_t
    for (genvar s = 0; s < NSGI; s++) begin : g_s
      assign sgi_source[(t*NSGI+s)*NCPU +: NCPU] = src_q[t][s];
      assign sgi_pending[t*NSGI+s] = |src_q[t][s];
    end
  end
endmodule

module sgi_tracker_checker #(
  parameter int NCPU = 8,
  parameter int NSGI = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [$clog2(NCPU+1)-1:0] cpus_present,
  input logic                      acc_valid,
  input logic                      acc_write,
  input logic                      acc_byte,
  input logic [$clog2(NCPU)-1:0]   acc_cpu,
  input logic [5:0]                acc_addr,
  input logic [31:0]               acc_wdata,
  input logic                      rd_valid,
  input logic [31:0]               rd_data,
  input logic [NCPU*NSGI*NCPU-1:0] sgi_source
);
  wire gen_wr = acc_valid && acc_write && acc_addr[5:2] == 4'h0;
  wire gen_rd = acc_valid && !acc_write && acc_addr[5:2] == 4'h0;

  logic [NCPU*NSGI*NCPU-1:0] absent_mask;
  always_comb begin
    absent_mask = '0;
    for (int t = 0; t < NCPU; t++)
      if (t >= int'(cpus_present))
        absent_mask[t*NSGI*NCPU +: NSGI*NCPU] = '1;
  end

  int self_idx;
  assign self_idx = (int'(acc_cpu) * NSGI + int'(acc_wdata[3:0])) * NCPU + int'(acc_cpu);

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> $stable(sgi_source));
  p_reserved_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_wr && acc_wdata[25:24] == 2'd3) |=> $stable(sgi_source));
  p_absent_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gen_wr |=> ((sgi_source ^ $past(sgi_source)) & $past(absent_mask)) == '0);
  p_self_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_wr && acc_wdata[25:24] == 2'd2) |=> sgi_source[$past(self_idx)]);
  p_gen_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gen_rd |=> (rd_valid && rd_data == 32'h0));
  p_byte_read_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_byte) |=> rd_data[31:8] == 24'h0);
endmodule

bind sgi_tracker sgi_tracker_checker #(.NCPU(NCPU), .NSGI(NSGI)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpus_present(cpus_present),
  .acc_valid(acc_valid), .acc_write(acc_write), .acc_byte(acc_byte),
  .acc_cpu(acc_cpu), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
  .rd_valid(rd_valid), .rd_data(rd_data), .sgi_source(sgi_source)
);

// File: tb/sgi_tracker_bench.sv
module sgi_tracker_bench;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [3:0]   cpus_present = 4'd4;
  logic         acc_valid = 0, acc_write = 0, acc_byte = 0;
  logic [2:0]   acc_cpu = '0;
  logic [5:0]   acc_addr = '0;
  logic [31:0]  acc_wdata = '0;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic [127:0] sgi_pending;
  logic [1023:0] sgi_source;

  sgi_tracker u_sgi_tracker (.*);

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  logic [7:0] m_src [8][16];
  logic [31:0] exp_q [$];
  string tag_q [$];
  bit done = 0;

  task automatic report;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic access(input bit w, input bit b, input int cpu, input logic [5:0] a,
                        input logic [31:0] d);
    acc_valid = 1; acc_write = w; acc_byte = b; acc_cpu = 3'(cpu);
    acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_byte = 0;
  endtask

  task automatic gen(input int cpu, input int mode, input logic [7:0] list, input int sgi, input string tag);
    logic [7:0] pres, tg;
    pres = 8'((16'd1 << cpus_present) - 1);
    case (mode)
      0: tg = list & pres;
      1: tg = pres & ~(8'd1 << cpu);
      2: tg = 8'd1 << cpu;
      default: tg = 8'd0;
    endcase
    for (int t = 0; t < 8; t++) if (tg[t]) m_src[t][sgi] |= (8'd1 << cpu);
    access(1, 0, cpu, 6'h00, {6'd0, 2'(mode), list, 12'd0, 4'(sgi)});
    check_state(tag);
  endtask

  task automatic win_wr(input bit set, input bit b, input int cpu, input logic [5:0] a,
                        input logic [31:0] d, input string tag);
    for (int i = 0; i < (b ? 1 : 4); i++) begin
      int s; logic [7:0] v;
      s = b ? int'(a[3:0]) : int'({a[3:2], 2'(i)});
      v = b ? d[7:0] : d[8*i +: 8];
      if (set) m_src[cpu][s] |= v; else m_src[cpu][s] &= ~v;
    end
    access(1, b, cpu, {set ? 2'b10 : 2'b01, a[3:0]}, d);
    check_state(tag);
  endtask

  task automatic rd(input bit b, input int cpu, input logic [5:0] a, input string tag);
    logic [31:0] e;
    e = '0;
    if (a[5:4] == 2'b01 || a[5:4] == 2'b10) begin
      if (b) e[7:0] = m_src[cpu][a[3:0]];
      else for (int i = 0; i < 4; i++) e[8*i +: 8] = m_src[cpu][{a[3:2], 2'(i)}];
    end
    exp_q.push_back(e); tag_q.push_back(tag);
    access(0, b, cpu, a, 32'hDEAD_BEEF);
  endtask

  task automatic check_state(input string tag);
    logic [1023:0] es; logic [127:0] ep;
    for (int t = 0; t < 8; t++)
      for (int s = 0; s < 16; s++) begin
        es[(t*16+s)*8 +: 8] = m_src[t][s];
        ep[t*16+s] = |m_src[t][s];
      end
    checks++;
    if (sgi_source !== es) begin
      errors++;
      $display("FAIL %s source: actual=%h expected=%h", tag, sgi_source, es);
    end
    checks++;
    if (sgi_pending !== ep) begin
      errors++;
      $display("FAIL %s/R8 pending: actual=%h expected=%h", tag, sgi_pending, ep);
    end
  endtask

  always @(negedge clk) if (rst_n && rd_valid) begin
    logic [31:0] e; string tg;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R9 unexpected read: actual=%h expected=none", rd_data);
    end else begin
      e = exp_q.pop_front(); tg = tag_q.pop_front();
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s read: actual=%h expected=%h", tg, rd_data, e);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  initial begin
    for (int t = 0; t < 8; t++) for (int s = 0; s < 16; s++) m_src[t][s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1");
    gen(1, 0, 8'hA5, 3, "R2/R6");
    gen(0, 0, 8'h0F, 0, "R2");
    gen(2, 1, 8'h00, 7, "R3");
    gen(3, 2, 8'hFF, 15, "R4");
    gen(0, 3, 8'hFF, 1, "R5");
    rd(0, 0, 6'h00, "R7");
    rd(0, 0, 6'h10, "R9");
    rd(0, 0, 6'h24, "R9");
    rd(1, 1, 6'h27, "R9");
    rd(1, 3, 6'h1F, "R9");
    win_wr(1, 0, 2, 6'h28, 32'h0300_8001, "R10");
    rd(0, 2, 6'h18, "R10");
    win_wr(1, 1, 2, 6'h25, 32'hFFFF_FF11, "R12");
    rd(0, 2, 6'h14, "R12");
    win_wr(0, 1, 0, 6'h13, 32'h0000_0002, "R11");
    win_wr(0, 0, 2, 6'h18, 32'h0200_0080, "R11");
    rd(0, 2, 6'h28, "R11");
    repeat (5) @(negedge clk);
    check_state("R13");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing reads: actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    report();
  end
endmodule